// File: doc/BRIEF.md
# Banked Level-Interrupt Controller

This block gathers 128 level-sensitive interrupt sources into one request line for a processor. Per-source state lives in four 32-bit banks. Each bank holds an enable mask, a security mask, a software-set mask and a wakeup mask. The enable mask changes only through write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write. A source is pending while its synchronized level, or its software-set bit, is high and it is enabled. The request output is raised whenever any source is pending and the global enable is on.

For low power, software writes 1 to a sleep hold-off register and reads it back. The controller grants the hold-off (the register reads 1) only if nothing is pending at that moment. While the hold-off is granted, the wake output follows any synchronized source level that the wakeup masks select. Writing 0 releases the hold-off.

The register bus is a single-cycle write strobe with combinational read data. Writes take effect at the rising clock edge on which the strobe is high.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Source n maps to bank n>>5, bit n&31. Bank k of each bank kind sits at that kind's base plus 4*k. The bases are: security 0x080, enable-set 0x100, enable-clear 0x180, software-set 0x200, software-clear 0x280, pending 0xD00, pending mirror 0xD80, wakeup 0xE00.
- R2: After reset, every mask, the control word, the priority mask, the synchronizer control and the hold-off all read 0, and both outputs are low.
- R3: Writing to an enable-set bank ORs the written ones into that bank's enable mask. Both the enable-set and the enable-clear offsets read back the current enable mask.
- R4: Writing to an enable-clear bank clears the enable bits where ones are written, and keeps all other bits. Writing all-ones disables every source of that bank.
- R5: Writing to a software-set bank ORs ones into the software-set mask, and writing to a software-clear bank clears the written ones. Both offsets read back the software-set mask.
- R6: Writing value n to offset 0xF00 sets the software-set bit of source n, where bits [6:5] give the bank and bits [4:0] give the bit. This offset reads 0.
- R7: The pending mask for each bank is (synchronized level OR software-set) AND enable, and it reads back at both 0xD00+4k and 0xD80+4k. A level change on a source reaches the pending mask after the second rising clock edge.
- R8: irq_out is high exactly when bit 0 of the control word is 1 and at least one pending bit is set.
- R9: Writing 1 in bit 0 of offset 0x014 grants the hold-off only when no pending bit is set, and a refused request reads back 0. Writing 0 releases the hold-off. The offset reads 1 only while the hold-off is granted.
- R10: The wakeup banks are read/write. wake_out is high exactly when the hold-off is granted and some synchronized level is high whose wakeup bit is set.
- R11: The control word (0x000) is 32 bits read/write. The priority mask (0x00C) keeps only bits [4:0], and the synchronizer control (0x010) keeps only bits [1:0]. The security banks are read/write.
- R12: Offset 0x004 reads 128. Writes to read-only offsets, unmapped offsets, bank indexes of 4 or more, or addresses that are not word-aligned change nothing. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_level | input | 128 | Raw level-sensitive source inputs |
| irq_out | output | 1 | Interrupt request |
| wake_out | output | 1 | Wakeup request while the hold-off is granted |

## Verification
The hardest case to reach is a refused hold-off. The refusal depends on the pending state at the instant of the write, and that state itself depends on the enables, the software bits and a two-edge synchronizer. To reach it, the bench first grants the hold-off with every enable cleared and shows that a masked level drives wake_out. It then releases the hold-off, enables the source that is still asserted, and shows that a new request reads back 0. A sweep over all 128 sources checks that irq_out stays low one edge after the input changes and rises on the next edge, so the synchronizer depth and the bank/bit mapping are checked together.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_W     = 32;
    localparam int NUM_BANKS  = 4;
    localparam int NUM_SRC    = BANK_W * NUM_BANKS;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int BIT_W      = $clog2(BANK_W);
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int PRIO_W     = 5;
    localparam int SYNCC_W    = 2;

    typedef enum logic [3:0] {
        K_NONE, K_CTRL, K_TYPE, K_PRIO, K_SYNC, K_HOLD,
        K_SEC, K_ENS, K_ENC, K_SRS, K_SRC, K_PND, K_HIP, K_WAK, K_SWI
    } kind_e;

    typedef struct packed {
        kind_e                 kind;
        logic [BANK_IDX_W-1:0] bank;
    } dec_t;

    typedef struct packed {
        logic [BANK_W-1:0] sec;
        logic [BANK_W-1:0] en;
        logic [BANK_W-1:0] sw;
        logic [BANK_W-1:0] wk;
    } bank_st_t;

    // Address decode: word-aligned only; banked regions use bits [6:2] as bank index.
    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.kind = K_NONE;
        d.bank = a[2 +: BANK_IDX_W];
        if (a[1:0] == 2'b00) begin
            if (a[11:7] == 5'h00) begin
                case (a[6:2])
                    5'd0:    d.kind = K_CTRL;
                    5'd1:    d.kind = K_TYPE;
                    5'd3:    d.kind = K_PRIO;
                    5'd4:    d.kind = K_SYNC;
                    5'd5:    d.kind = K_HOLD;
                    default: d.kind = K_NONE;
                endcase
            end else if (a[11:7] == 5'h1E) begin
                if (a[6:2] == 5'd0) d.kind = K_SWI;
            end else if (a[6:2] < 5'(NUM_BANKS)) begin
                case (a[11:7])
                    5'h01:   d.kind = K_SEC;
                    5'h02:   d.kind = K_ENS;
                    5'h03:   d.kind = K_ENC;
                    5'h04:   d.kind = K_SRS;
                    5'h05:   d.kind = K_SRC;
                    5'h1A:   d.kind = K_PND;
                    5'h1B:   d.kind = K_HIP;
                    5'h1C:   d.kind = K_WAK;
                    default: d.kind = K_NONE;
                endcase
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] raw,
    input  logic              we_sec,
    input  logic              we_ens,
    input  logic              we_enc,
    input  logic              we_srs,
    input  logic              we_src,
    input  logic              we_wak,
    input  logic [BANK_W-1:0] sw_hit,
    input  logic [BANK_W-1:0] wdata,
    output bank_st_t          st,
    output logic [BANK_W-1:0] pend,
    output logic              wake_any
);
    bank_st_t nxt;

    always_comb begin
        nxt = st;
        if (we_sec) nxt.sec = wdata;
        if (we_ens) nxt.en  = st.en | wdata;
        if (we_enc) nxt.en  = st.en & ~wdata;
        if (we_srs) nxt.sw  = st.sw | wdata;
        if (we_src) nxt.sw  = st.sw & ~wdata;
        nxt.sw = nxt.sw | sw_hit;
        if (we_wak) nxt.wk  = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    assign pend     = (raw | st.sw) & st.en;
    assign wake_any = |(raw & st.wk);

    a_r3_set_bits_enabled: assert property (@(posedge clk) disable iff (rst)
        we_ens |=> ((st.en & $past(wdata)) == $past(wdata)));
    a_r4_clear_bits_disabled: assert property (@(posedge clk) disable iff (rst)
        we_enc |=> ((st.en & $past(wdata)) == '0));
    a_r4_clear_keeps_others: assert property (@(posedge clk) disable iff (rst)
        we_enc |=> ((st.en & ~$past(wdata)) == ($past(st.en) & ~$past(wdata))));
    a_r5_sw_clear: assert property (@(posedge clk) disable iff (rst)
        (we_src && sw_hit == '0) |=> ((st.sw & $past(wdata)) == '0));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_level,
    output logic              irq_out,
    output logic              wake_out
);
    dec_t dec;
    assign dec = decode(bus_addr);

    logic [NUM_SRC-1:0] src_sync;
    irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .d(src_level), .q(src_sync)
    );

    bank_st_t                        st_a [NUM_BANKS];
    logic [NUM_BANKS-1:0][BANK_W-1:0] pend_a;
    logic [NUM_BANKS-1:0]            wake_v;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              sel;
        logic [BANK_W-1:0] hit;
        assign sel = bus_we && (dec.bank == BANK_IDX_W'(b));
        assign hit = (bus_we && dec.kind == K_SWI &&
                      bus_wdata[BIT_W +: BANK_IDX_W] == BANK_IDX_W'(b))
                     ? (BANK_W'(1) << bus_wdata[BIT_W-1:0]) : '0;
        irqc_bank i_bank (
            .clk(clk), .rst(rst),
            .raw(src_sync[b*BANK_W +: BANK_W]),
            .we_sec(sel && dec.kind == K_SEC),
            .we_ens(sel && dec.kind == K_ENS),
            .we_enc(sel && dec.kind == K_ENC),
            .we_srs(sel && dec.kind == K_SRS),
            .we_src(sel && dec.kind == K_SRC),
            .we_wak(sel && dec.kind == K_WAK),
            .sw_hit(hit),
            .wdata(bus_wdata),
            .st(st_a[b]),
            .pend(pend_a[b]),
            .wake_any(wake_v[b])
        );
    end

    logic               any_pend;
    logic [DATA_W-1:0]  ctrl_q;
    logic [PRIO_W-1:0]  prio_q;
    logic [SYNCC_W-1:0] syncc_q;
    logic               hold_q;

    assign any_pend = |pend_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            prio_q  <= '0;
            syncc_q <= '0;
            hold_q  <= 1'b0;
        end else if (bus_we) begin
            case (dec.kind)
                K_CTRL:  ctrl_q  <= bus_wdata;
                K_PRIO:  prio_q  <= bus_wdata[PRIO_W-1:0];
                K_SYNC:  syncc_q <= bus_wdata[SYNCC_W-1:0];
                K_HOLD:  hold_q  <= bus_wdata[0] & ~any_pend;
                default: ;
            endcase
        end
    end

    assign irq_out  = ctrl_q[0] & any_pend;
    assign wake_out = hold_q & (|wake_v);

    always_comb begin
        bus_rdata = '0;
        case (dec.kind)
            K_CTRL:       bus_rdata = ctrl_q;
            K_TYPE:       bus_rdata = DATA_W'(NUM_SRC);
            K_PRIO:       bus_rdata = DATA_W'(prio_q);
            K_SYNC:       bus_rdata = DATA_W'(syncc_q);
            K_HOLD:       bus_rdata = DATA_W'(hold_q);
            K_SEC:        bus_rdata = st_a[dec.bank].sec;
            K_ENS, K_ENC: bus_rdata = st_a[dec.bank].en;
            K_SRS, K_SRC: bus_rdata = st_a[dec.bank].sw;
            K_PND, K_HIP: bus_rdata = pend_a[dec.bank];
            K_WAK:        bus_rdata = st_a[dec.bank].wk;
            default:      bus_rdata = '0;
        endcase
    end

    a_r8_irq_needs_global_en: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ctrl_q[0]);
    a_r9_hold_refused: assert property (@(posedge clk) disable iff (rst)
        (bus_we && dec.kind == K_HOLD && bus_wdata[0] && any_pend) |=> !hold_q);
    a_r9_hold_release: assert property (@(posedge clk) disable iff (rst)
        (bus_we && dec.kind == K_HOLD && !bus_wdata[0]) |=> !hold_q);
    a_r10_wake_needs_hold: assert property (@(posedge clk) disable iff (rst)
        wake_out |-> hold_q);
    a_r11_prio_width: assert property (@(posedge clk) disable iff (rst)
        (bus_we && dec.kind == K_PRIO) |=> (prio_q == $past(bus_wdata[PRIO_W-1:0])));
    a_r12_type_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && dec.kind == K_TYPE) |=> ($stable(ctrl_q) && $stable(hold_q)));
endmodule

// File: tb/test_banked_irq_ctrl.sv
`timescale 1ns/1ps
module test_banked_irq_ctrl;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_we = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] src_level = '0;
    logic         irq_out;
    logic         wake_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rv;

    localparam logic [11:0] A_CTRL = 12'h000, A_TYPE = 12'h004, A_PRIO = 12'h00C,
        A_SYNC = 12'h010, A_HOLD = 12'h014, A_SEC = 12'h080, A_ENS = 12'h100,
        A_ENC = 12'h180, A_SRS = 12'h200, A_SRC = 12'h280, A_PND = 12'hD00,
        A_HIP = 12'hD80, A_WAK = 12'hE00, A_SWI = 12'hF00;

    always #2.5 clk = ~clk;

    banked_irq_ctrl i_banked_irq_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_level(src_level),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a;
        #1 rv = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 / R12: reset state and constant type
        chk("R2 irq reset", 32'(irq_out), 0);
        chk("R2 wake reset", 32'(wake_out), 0);
        rd(A_CTRL); chk("R2 ctrl", rv, 0);
        rd(A_PRIO); chk("R2 prio", rv, 0);
        rd(A_HOLD); chk("R2 hold", rv, 0);
        rd(A_TYPE); chk("R12 type", rv, 128);
        for (int b = 0; b < 4; b++) begin
            rd(A_SEC + 12'(4*b)); chk("R2 sec", rv, 0);
            rd(A_ENS + 12'(4*b)); chk("R2 en", rv, 0);
            rd(A_SRS + 12'(4*b)); chk("R2 sw", rv, 0);
            rd(A_PND + 12'(4*b)); chk("R2 pend", rv, 0);
            rd(A_WAK + 12'(4*b)); chk("R2 wake mask", rv, 0);
        end

        // R11: scalar registers and security banks
        wr(A_CTRL, 32'h8001_0001); rd(A_CTRL); chk("R11 ctrl", rv, 32'h8001_0001);
        wr(A_PRIO, 32'hFFFF_FFFF); rd(A_PRIO); chk("R11 prio", rv, 32'h1F);
        wr(A_SYNC, 32'hFF);        rd(A_SYNC); chk("R11 sync wide", rv, 32'h3);
        wr(A_SYNC, 32'h02);        rd(A_SYNC); chk("R11 sync", rv, 32'h2);
        for (int b = 0; b < 4; b++) begin
            wr(A_SEC + 12'(4*b), 32'h1234_5678 * (b + 3));
            rd(A_SEC + 12'(4*b)); chk("R11 sec", rv, 32'h1234_5678 * (b + 3));
        end

        // R3 / R4: set/clear aliases
        for (int b = 0; b < 4; b++) begin
            logic [31:0] p1, p2, p3, m;
            p1 = 32'hA5A5_0000 ^ (32'h0101 << b);
            p2 = 32'h0F0F_00F0 >> b;
            p3 = 32'h00FF_FF00 ^ 32'(b);
            wr(A_ENS + 12'(4*b), p1); m = p1;
            rd(A_ENS + 12'(4*b)); chk("R3 set", rv, m);
            wr(A_ENS + 12'(4*b), p2); m = m | p2;
            rd(A_ENS + 12'(4*b)); chk("R3 set or", rv, m);
            rd(A_ENC + 12'(4*b)); chk("R3 clear alias read", rv, m);
            wr(A_ENC + 12'(4*b), p3); m = m & ~p3;
            rd(A_ENS + 12'(4*b)); chk("R4 clear", rv, m);
            wr(A_ENC + 12'(4*b), 32'hFFFF_FFFF);
            rd(A_ENS + 12'(4*b)); chk("R4 clear all", rv, 0);
        end

        // R1 / R7 / R8: sweep all sources through the synchronizer
        for (int b = 0; b < 4; b++) wr(A_ENS + 12'(4*b), 32'hFFFF_FFFF);
        for (int n = 0; n < 128; n++) begin
            @(negedge clk);
            src_level = '0; src_level[n] = 1'b1;
            @(negedge clk); #1 chk("R7 one edge", 32'(irq_out), 0);
            @(negedge clk); #1 chk("R8 irq up", 32'(irq_out), 1);
            rd(A_PND + 12'(4*(n >> 5))); chk("R1 pend bit", rv, 32'h1 << (n & 31));
            rd(A_HIP + 12'(4*(n >> 5))); chk("R7 mirror", rv, 32'h1 << (n & 31));
            @(negedge clk); src_level = '0;
            @(negedge clk); @(negedge clk); #1 chk("R8 irq down", 32'(irq_out), 0);
        end

        // R8: global enable gates request
        @(negedge clk); src_level[70] = 1'b1;
        repeat (2) @(negedge clk);
        wr(A_CTRL, 32'h0); #1 chk("R8 gated", 32'(irq_out), 0);
        rd(A_PND + 12'd8); chk("R7 pend while gated", rv, 32'h40);
        wr(A_CTRL, 32'h1); #1 chk("R8 ungated", 32'(irq_out), 1);
        wr(A_ENC + 12'd8, 32'h40); #1 chk("R7 disabled source", 32'(irq_out), 0);
        @(negedge clk); src_level = '0;
        for (int b = 0; b < 4; b++) wr(A_ENC + 12'(4*b), 32'hFFFF_FFFF);

        // R5: software set/clear
        wr(A_ENS + 12'd8, 32'h0000_FFFF);
        wr(A_SRS + 12'd8, 32'h00FF_00FF);
        rd(A_SRS + 12'd8); chk("R5 sw set", rv, 32'h00FF_00FF);
        rd(A_PND + 12'd8); chk("R7 sw pend", rv, 32'h0000_00FF);
        #1 chk("R8 sw irq", 32'(irq_out), 1);
        wr(A_SRC + 12'd8, 32'h0000_00F0);
        rd(A_SRC + 12'd8); chk("R5 sw clear", rv, 32'h00FF_000F);
        rd(A_PND + 12'd8); chk("R7 sw pend after clear", rv, 32'h0000_000F);
        wr(A_SRC + 12'd8, 32'hFFFF_FFFF);
        #1 chk("R5 irq after clear", 32'(irq_out), 0);
        wr(A_ENC + 12'd8, 32'hFFFF_FFFF);

        // R6: software interrupt by number
        foreach (rv[i]) ; // no-op keeps rv declared use
        for (int k = 0; k < 5; k++) begin
            int n;
            n = (k == 0) ? 0 : (k == 1) ? 31 : (k == 2) ? 32 : (k == 3) ? 77 : 127;
            wr(A_SWI, 32'(n));
            rd(A_SRS + 12'(4*(n >> 5)));
            chk("R6 swint bit", rv & (32'h1 << (n & 31)), 32'h1 << (n & 31));
        end
        rd(A_SWI); chk("R6 swint reads 0", rv, 0);
        rd(A_SRS + 12'd0);  chk("R6 bank0", rv, 32'h8000_0001);
        rd(A_SRS + 12'd4);  chk("R6 bank1", rv, 32'h0000_0001);
        rd(A_SRS + 12'd8);  chk("R6 bank2", rv, 32'h0000_2000);
        rd(A_SRS + 12'd12); chk("R6 bank3", rv, 32'h8000_0000);
        for (int b = 0; b < 4; b++) wr(A_SRC + 12'(4*b), 32'hFFFF_FFFF);

        // R9 / R10: hold-off and wake
        wr(A_WAK + 12'd4, 32'h8);
        rd(A_WAK + 12'd4); chk("R10 wake mask rw", rv, 32'h8);
        wr(A_HOLD, 32'h1); rd(A_HOLD); chk("R9 granted", rv, 1);
        @(negedge clk); src_level[35] = 1'b1;
        @(negedge clk); #1 chk("R10 wake sync", 32'(wake_out), 0);
        @(negedge clk); #1 chk("R10 wake up", 32'(wake_out), 1);
        @(negedge clk); src_level[35] = 1'b0; src_level[36] = 1'b1;
        repeat (2) @(negedge clk); #1 chk("R10 unmasked no wake", 32'(wake_out), 0);
        @(negedge clk); src_level = '0; src_level[35] = 1'b1;
        repeat (2) @(negedge clk);
        wr(A_HOLD, 32'h0); rd(A_HOLD); chk("R9 released", rv, 0);
        #1 chk("R10 no wake released", 32'(wake_out), 0);
        wr(A_ENS + 12'd4, 32'h8);
        wr(A_HOLD, 32'h1); rd(A_HOLD); chk("R9 refused", rv, 0);
        #1 chk("R10 refused no wake", 32'(wake_out), 0);
        chk("R8 pending irq", 32'(irq_out), 1);
        wr(A_ENC + 12'd4, 32'hFFFF_FFFF);
        @(negedge clk); src_level = '0;

        // R12: ignored writes and unmapped reads
        wr(12'h110, 32'hFFFF_FFFF); rd(12'h110); chk("R12 bank4 read", rv, 0);
        for (int b = 0; b < 4; b++) begin
            rd(A_ENS + 12'(4*b)); chk("R12 bank4 write ignored", rv, 0);
        end
        wr(12'h102, 32'hFFFF_FFFF); rd(A_ENS); chk("R12 misaligned ignored", rv, 0);
        wr(A_PND, 32'hFFFF_FFFF);   rd(A_PND); chk("R12 pend ro", rv, 0);
        wr(A_TYPE, 32'h0);          rd(A_TYPE); chk("R12 type ro", rv, 128);
        wr(12'h300, 32'hDEAD_BEEF); rd(12'h300); chk("R12 unmapped", rv, 0);
        rd(12'h008); chk("R12 unmapped id", rv, 0);
        rd(A_CTRL); chk("R12 ctrl unchanged", rv, 32'h1);

        finish_run();
    end
endmodule